// File: doc/BRIEF.md
# Two-Wire Control Bus Router

This block sits on an upstream two-wire control bus and decides which of three targets the bus reaches. The three targets are a local register slave, an external configuration PROM port and a display DDC port. It samples the bus clock and data lines with the system clock and recognises START and STOP conditions. After each START it captures the address byte. From these events, and from route-select writes issued by the register block, a small state machine chooses the current route.

Three one-hot outputs carry the route. Two of them enable the pass-through switches toward the PROM and DDC ports. The third tells the local register slave that it owns the bus and should respond.

After reset the bus goes to the PROM, and the router only listens. If an address aimed at the local device is seen, the PROM path is cut and the local registers take the bus. From there, a register command sends the bus to the PROM or to DDC. Once on DDC, a STOP that follows a START hands the bus back to the local registers.

Top module: `ctl_bus_router`

## Requirements
- R1: While reset is active, and after it is released, the route is PROM: `prom_en_o`=1, `local_sel_o`=0, `ddc_en_o`=0.
- R2: Exactly one of `prom_en_o`, `local_sel_o` and `ddc_en_o` is high in every cycle.
- R3: The local 7-bit address is 0111_00 followed by the inverse of `addr_sel_i`. With `addr_sel_i`=0 the address bytes 72h and 73h match, and with `addr_sel_i`=1 the bytes 70h and 71h match. The read/write bit (bit 0) is ignored.
- R4: In the PROM route, a matching address switches the route to local. The switch happens on the 9th SCL rising edge after START (the ACK clock). The outputs change on the third `clk_i` edge after that SCL rise reaches the pins. A non-matching address leaves the route on PROM.
- R5: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits clocked without a preceding START are not captured as an address.
- R6: In the local route, a one-cycle write with `route_wr_i`=1 takes effect on the next clock edge. A value of 2'b01 on `route_sel_i` selects PROM, and 2'b10 selects DDC.
- R7: A route write with `route_sel_i` of 2'b00 or 2'b11 leaves the route unchanged. A route write made while the route is not local has no effect.
- R8: In the DDC route, only a STOP that follows a START seen since DDC was entered returns the route to local. A lone STOP has no effect, and neither does a matching address.
- R9: A repeated START restarts address capture from the first bit.
- R10: A STOP before the ACK clock abandons the address, so no route change follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Upstream bus clock line |
| sda_i | input | 1 | Upstream bus data line |
| addr_sel_i | input | 1 | Address select; the inverse forms address bit 0 |
| route_wr_i | input | 1 | One-cycle strobe from the register block for a route write |
| route_sel_i | input | 2 | Route code: 01 PROM, 10 DDC, others ignored |
| prom_en_o | output | 1 | Enables the PROM pass-through switch |
| local_sel_o | output | 1 | Tells the local register slave to respond |
| ddc_en_o | output | 1 | Enables the DDC pass-through switch |

## Verification
The address matcher is exercised with a non-matching byte, with a byte that matches only under the other select setting, and with both read and write forms of the local address. Together these separate matching on the select input from matching on the R/W bit. Bus sequences are also sent that look like an address but are not one: bits clocked with no START, an address cut short by a STOP, an address restarted by a repeated START, and a lone STOP while on DDC. These show whether the framing logic, rather than the raw bit stream, drives the route. Route writes with legal, illegal and out-of-state codes show that only the local route accepts commands. A per-clock model checks the exact cycle of every route change.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    RT_PROM  = 2'd0,
    RT_LOCAL = 2'd1,
    RT_DDC   = 2'd2
  } route_e;

  localparam logic [1:0] SEL_PROM = 2'b01;
  localparam logic [1:0] SEL_DDC  = 2'b10;
endpackage

// File: rtl/cbr_sync.sv
module cbr_sync #(
  parameter int unsigned      STAGES  = 2,
  parameter int unsigned      W       = 2,
  parameter logic [W-1:0]     RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cbr_cond_det.sv
module cbr_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // conditions require SCL high on both samples around the SDA edge
  assign start_o    = scl_q & scl_s_i &  sda_q & ~sda_s_i;
  assign stop_o     = scl_q & scl_s_i & ~sda_q &  sda_s_i;
  assign scl_rise_o = ~scl_q & scl_s_i;
endmodule

// File: rtl/cbr_addr_cap.sv
module cbr_addr_cap #(
  parameter int unsigned            ADDR_W  = 7,
  parameter logic [ADDR_W-2:0]      ADDR_HI = 6'b011100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_rise_i,
  input  logic sda_s_i,
  input  logic addr_sel_i,
  output logic hit_o
);
  localparam int unsigned BYTE_BITS = ADDR_W + 1;
  localparam int unsigned CNT_W     = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] RW_CNT  = CNT_W'(ADDR_W);

  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] shreg_q;
  logic [ADDR_W-1:0] own_addr;

  assign own_addr = {ADDR_HI, ~addr_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (stop_i) begin
      armed_q <= 1'b0;
    end else if (scl_rise_i && armed_q) begin
      if (cnt_q == ACK_CNT) begin
        armed_q <= 1'b0;
      end else begin
        // R/W bit is clocked past without being stored
        if (cnt_q < RW_CNT) shreg_q <= {shreg_q[ADDR_W-2:0], sda_s_i};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hit_o = armed_q & scl_rise_i & ~start_i & ~stop_i &
                 (cnt_q == ACK_CNT) & (shreg_q == own_addr);
endmodule

// File: rtl/cbr_route_fsm.sv
module cbr_route_fsm
  import cbr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       wr_i,
  input  logic [1:0] sel_i,
  output route_e     route_o
);
  route_e route_q, route_d;
  logic   seen_start_q;

  always_comb begin
    route_d = route_q;
    unique case (route_q)
      RT_PROM:  if (hit_i) route_d = RT_LOCAL;
      RT_LOCAL: if (wr_i) begin
        if (sel_i == SEL_PROM)     route_d = RT_PROM;
        else if (sel_i == SEL_DDC) route_d = RT_DDC;
      end
      RT_DDC:   if (stop_i && seen_start_q) route_d = RT_LOCAL;
      default:  route_d = RT_PROM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q      <= RT_PROM;
      seen_start_q <= 1'b0;
    end else begin
      route_q <= route_d;
      // only STARTs seen since DDC was entered count
      if (route_q != RT_DDC) seen_start_q <= 1'b0;
      else if (start_i)      seen_start_q <= 1'b1;
    end
  end

  assign route_o = route_q;
endmodule

// File: rtl/ctl_bus_router.sv
module ctl_bus_router
  import cbr_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       ADDR_W      = 7,
  parameter logic [ADDR_W-2:0] ADDR_HI     = 6'b011100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  input  logic       route_wr_i,
  input  logic [1:0] route_sel_i,
  output logic       prom_en_o,
  output logic       local_sel_o,
  output logic       ddc_en_o
);
  logic [1:0] bus_s;
  logic       start_det, stop_det, scl_rise;
  logic       addr_hit;
  route_e     route;

  cbr_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (bus_s)
  );

  cbr_cond_det u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (bus_s[1]),
    .sda_s_i    (bus_s[0]),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .scl_rise_o (scl_rise)
  );

  cbr_addr_cap #(.ADDR_W(ADDR_W), .ADDR_HI(ADDR_HI)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .scl_rise_i (scl_rise),
    .sda_s_i    (bus_s[0]),
    .addr_sel_i (addr_sel_i),
    .hit_o      (addr_hit)
  );

  cbr_route_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (addr_hit),
    .start_i (start_det),
    .stop_i  (stop_det),
    .wr_i    (route_wr_i),
    .sel_i   (route_sel_i),
    .route_o (route)
  );

  assign prom_en_o   = (route == RT_PROM);
  assign local_sel_o = (route == RT_LOCAL);
  assign ddc_en_o    = (route == RT_DDC);
endmodule

// File: rtl/cbr_router_chk.sv
module cbr_router_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prom_en_o,
  input logic       local_sel_o,
  input logic       ddc_en_o,
  input logic       route_wr_i,
  input logic [1:0] route_sel_i,
  input logic       addr_hit,
  input logic       stop_det
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_PROM: assert (prom_en_o && !local_sel_o && !ddc_en_o); // R1
    end
  end

  AST_ONE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({prom_en_o, local_sel_o, ddc_en_o}) == 1); // R2

  AST_PROM_TO_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prom_en_o && addr_hit |=> local_sel_o); // R4

  AST_PROM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prom_en_o && !addr_hit |=> prom_en_o); // R4

  AST_WR_DDC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_sel_o && route_wr_i && route_sel_i == 2'b10 |=> ddc_en_o); // R6

  AST_WR_PROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_sel_o && route_wr_i && route_sel_i == 2'b01 |=> prom_en_o); // R6

  AST_WR_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_sel_o && route_wr_i && (route_sel_i == 2'b00 || route_sel_i == 2'b11)
    |=> local_sel_o); // R7

  AST_LOCAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_sel_o && !route_wr_i |=> local_sel_o); // R7

  AST_DDC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddc_en_o && !stop_det |=> ddc_en_o); // R8
endmodule

bind ctl_bus_router cbr_router_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prom_en_o   (prom_en_o),
  .local_sel_o (local_sel_o),
  .ddc_en_o    (ddc_en_o),
  .route_wr_i  (route_wr_i),
  .route_sel_i (route_sel_i),
  .addr_hit    (addr_hit),
  .stop_det    (stop_det)
);

// File: tb/ctl_bus_router_test.sv
`timescale 1ns/1ps
module ctl_bus_router_test;
  localparam logic [2:0] EXP_PROM  = 3'b100;
  localparam logic [2:0] EXP_LOCAL = 3'b010;
  localparam logic [2:0] EXP_DDC   = 3'b001;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic       asel = 1'b1;
  logic       wr = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       prom_en, local_sel, ddc_en;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  ctl_bus_router uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda),
    .addr_sel_i  (asel),
    .route_wr_i  (wr),
    .route_sel_i (sel),
    .prom_en_o   (prom_en),
    .local_sel_o (local_sel),
    .ddc_en_o    (ddc_en)
  );

  // behavioural reference: route 0 PROM, 1 local, 2 DDC
  logic [1:0] hist[$];
  int  m_route, m_cnt;
  bit  m_arm, m_seen;
  logic [6:0] m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{2'b11, 2'b11, 2'b11, 2'b11};
      m_route = 0; m_cnt = 0; m_arm = 0; m_seen = 0; m_addr = '0;
    end else begin
      logic [1:0] s, p;
      bit st, sp, rise, hit;
      hist.push_back({scl, sda});
      void'(hist.pop_front());
      p = hist[0]; s = hist[1];
      st   = p[1] && s[1] && p[0] && !s[0];
      sp   = p[1] && s[1] && !p[0] && s[0];
      rise = !p[1] && s[1];
      hit  = rise && m_arm && m_cnt == 8 && m_addr == {6'b011100, !asel};
      case (m_route)
        0: if (hit) m_route = 1;
        1: if (wr && sel == 2'b01) m_route = 0;
           else if (wr && sel == 2'b10) begin m_route = 2; m_seen = 0; end
        default: begin
          if (sp && m_seen) m_route = 1;
          else if (st) m_seen = 1;
        end
      endcase
      if (st) begin m_arm = 1; m_cnt = 0; end
      else if (sp) m_arm = 0;
      else if (rise && m_arm) begin
        if (m_cnt == 8) m_arm = 0;
        else begin
          if (m_cnt < 7) m_addr = {m_addr[5:0], s[0]};
          m_cnt++;
        end
      end
    end
  end

  function automatic logic [2:0] model_vec();
    return (m_route == 0) ? EXP_PROM : (m_route == 1) ? EXP_LOCAL : EXP_DDC;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({prom_en, local_sel, ddc_en} !== model_vec()) begin
        errors++;
        $display("FAIL %s per-cycle R2: got %b expected %b at %0t",
                 cur_req, {prom_en, local_sel, ddc_en}, model_vec(), $time);
      end
    end
  end

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({prom_en, local_sel, ddc_en} !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, {prom_en, local_sel, ddc_en}, exp);
    end
  endtask

  task automatic hp(); repeat (4) @(negedge clk); endtask
  task automatic settle(); repeat (8) @(negedge clk); endtask

  task automatic bus_start();
    sda = 1'b1; hp(); scl = 1'b1; hp(); sda = 1'b0; hp(); scl = 1'b0; hp();
  endtask
  task automatic bus_bit(input logic b);
    sda = b; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
  endtask
  task automatic bus_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(1'b1);
  endtask
  task automatic bus_stop();
    sda = 1'b0; hp(); scl = 1'b1; hp(); sda = 1'b1; hp();
  endtask
  task automatic xfer(input logic [7:0] v);
    bus_start(); bus_byte(v); bus_stop(); settle();
  endtask
  task automatic rwrite(input logic [1:0] v);
    @(negedge clk); wr = 1'b1; sel = v;
    @(negedge clk); wr = 1'b0; sel = 2'b00;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", EXP_PROM);
    rst_n = 1'b1;
    settle();
    check("R1 after reset", EXP_PROM);

    cur_req = "R4";
    xfer(8'h50);
    check("R4 foreign address", EXP_PROM);

    cur_req = "R3";
    asel = 1'b0;
    xfer(8'h70);
    check("R3 70h with select low", EXP_PROM);
    asel = 1'b1;
    xfer(8'h70);
    check("R3 R4 70h with select high", EXP_LOCAL);

    cur_req = "R7";
    rwrite(2'b00);
    check("R7 code 00", EXP_LOCAL);
    rwrite(2'b11);
    check("R7 code 11", EXP_LOCAL);
    cur_req = "R6";
    rwrite(2'b01);
    check("R6 to PROM", EXP_PROM);
    cur_req = "R7";
    rwrite(2'b10);
    check("R7 write outside local", EXP_PROM);

    cur_req = "R3";
    asel = 1'b0;
    xfer(8'h73);
    check("R3 73h read form", EXP_LOCAL);

    cur_req = "R6";
    rwrite(2'b10);
    check("R6 to DDC", EXP_DDC);

    cur_req = "R8";
    scl = 1'b0; hp(); bus_stop(); settle();
    check("R8 lone STOP", EXP_DDC);
    bus_start(); bus_byte(8'h72); settle();
    check("R8 address in DDC", EXP_DDC);
    bus_stop(); settle();
    check("R8 STOP after START", EXP_LOCAL);

    rwrite(2'b01);
    cur_req = "R9";
    bus_start();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b0);
    bus_start(); bus_byte(8'h72); settle();
    check("R9 repeated START", EXP_LOCAL);
    bus_stop();
    rwrite(2'b01);

    cur_req = "R10";
    bus_start();
    for (int i = 7; i >= 1; i--) bus_bit(8'h72 >> i);
    bus_stop(); settle();
    check("R10 STOP mid address", EXP_PROM);

    cur_req = "R5";
    scl = 1'b0; hp();
    bus_byte(8'h72);
    sda = 1'b1; hp(); scl = 1'b1; settle();
    check("R5 bits without START", EXP_PROM);

    cur_req = "R4";
    xfer(8'h72);
    check("R4 final match", EXP_LOCAL);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule